// File: doc/BRIEF.md
# Link event interrupt controller

This block gathers six single-cycle event strobes from the link and autonegotiation logic into a sticky flag register, and qualifies those flags with a software-written enable mask to drive one level-sensitive interrupt line. Software reaches both registers through a simple register port with an address, a read strobe, a write strobe and 16-bit data.

A flag bit sets on its event strobe whatever the mask holds, so software can poll events that it has not enabled. Reading the flag register returns the pending events and clears them in the same access, which is how the interrupt is acknowledged. The mask lives at its own address and is never changed by a read. An event that arrives in the same cycle as a clearing read is never lost: it survives the clear and shows on the next read.

The interrupt line is produced by a two-state machine, `IRQ_QUIET` and `IRQ_RAISED`. The transition `QUIET_TO_RAISED` is taken when the next flag and mask values share a set bit. `RAISED_TO_QUIET` is taken when they no longer do, either through a clearing read or through a mask write. The line therefore always equals the OR of flag AND mask as held in the registers. Read decoding uses three named selections: `SEL_FLAG`, `SEL_MASK` and `SEL_NONE`.

Top module: `link_evt_irq_ctrl`

## Requirements
- R1: After reset both registers hold 0, and `irq` is 0.
- R2: Strobe bit i of `evt_pulse` sets flag bit i+1, whatever the mask holds. The strobe bits map as follows: 0 page received, 1 parallel-detect fault, 2 partner acknowledge, 3 link down, 4 remote fault, 5 autonegotiation complete. A set flag stays set until it is read.
- R3: With `reg_rd`=1 and `reg_addr`=29, `reg_rdata` shows the flag register in that same cycle, and the flag register is 0 after the clock edge.
- R4: When a strobe arrives in the same cycle as a clearing read, the read returns the value from before the strobe, and that strobe's bit is still set after the edge.
- R5: With `reg_wr`=1 and `reg_addr`=30, bits 6..1 of `reg_wdata` are loaded into the mask. A read at address 30 returns the mask and leaves it unchanged. Writing 0 disables every source, and writing 0x007E enables all six.
- R6: `irq` is 1 exactly when some flag bit and its mask bit are both 1, using the register values after each clock edge.
- R7: Bits 0 and 15..7 of both registers always read 0, and writes to them are ignored. A write to address 29 has no effect on the flags.
- R8: `reg_rdata` is 0 when `reg_rd` is 0 or when `reg_addr` is neither 29 nor 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 6 | Event strobes, one cycle each |
| reg_addr | input | 5 | Register address |
| reg_rd | input | 1 | Read strobe (a read at 29 clears the flags) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of `reg_rd` |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: six events placed at bits 1 to 6 of a 16-bit word, with the flag register at address 29 and the mask at address 30. This leaves bit 0 and bits 15..7 unused, so the bench can check that they ignore writes. Because both addresses sit inside the 5-bit address space, neighbouring and unrelated addresses can also be read to confirm they return zero. A behavioural model tracks flags and mask every cycle, so strobes that collide with clearing reads and mask writes that drop `irq` are compared against their expected values as they happen.

// File: rtl/lei_pkg.sv
package lei_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_FLAG = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/lei_flag_bank.sv
module lei_flag_bank #(
    parameter int DATA_W  = 16,
    parameter int NUM_EVT = 6,
    parameter int EVT_LSB = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               clr_req,
    output logic [DATA_W-1:0]  flag_q,
    output logic [DATA_W-1:0]  flag_d
);
    localparam int EVT_MSB = EVT_LSB + NUM_EVT - 1;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b >= EVT_LSB && b <= EVT_MSB) begin : g_live
            // Event wins over the clearing read in the same cycle
            assign flag_d[b] = evt_pulse[b-EVT_LSB] | (flag_q[b] & ~clr_req);
        end else begin : g_dead
            assign flag_d[b] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_chk
        assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_pulse[e] |=> flag_q[e+EVT_LSB]);
        // R4: collision with a clearing read keeps the bit
        assert_collide_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req && evt_pulse[e]) |=> flag_q[e+EVT_LSB]);
    end

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && evt_pulse == '0) |=> flag_q == '0);

    assert_flag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && evt_pulse == '0) |=> $stable(flag_q));
endmodule

// File: rtl/lei_mask_reg.sv
module lei_mask_reg #(
    parameter int DATA_W  = 16,
    parameter int NUM_EVT = 6,
    parameter int EVT_LSB = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] mask_d
);
    localparam logic [DATA_W-1:0] KEEP = DATA_W'(((1 << NUM_EVT) - 1) << EVT_LSB);

    always_comb begin
        mask_d = mask_q;
        if (wr_req) mask_d = wdata & KEEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> $stable(mask_q));
endmodule

// File: rtl/lei_irq_fsm.sv
module lei_irq_fsm #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] flag_d,
    input  logic [DATA_W-1:0] mask_d,
    input  logic [DATA_W-1:0] flag_q,
    input  logic [DATA_W-1:0] mask_q,
    output logic              irq
);
    import lei_pkg::*;

    irq_state_e state_q, state_d;
    logic       pend_next;

    assign pend_next = |(flag_d & mask_d);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pend_next)  state_d = IRQ_RAISED; // QUIET_TO_RAISED
            IRQ_RAISED: if (!pend_next) state_d = IRQ_QUIET;  // RAISED_TO_QUIET
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

    assert_irq_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(flag_q & mask_q));
endmodule

// File: rtl/link_evt_irq_ctrl.sv
module link_evt_irq_ctrl #(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 5,
    parameter int NUM_EVT   = 6,
    parameter int EVT_LSB   = 1,
    parameter int FLAG_ADDR = 29,
    parameter int MASK_ADDR = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq
);
    import lei_pkg::*;

    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);
    localparam logic [DATA_W-1:0] KEEP   = DATA_W'(((1 << NUM_EVT) - 1) << EVT_LSB);

    reg_sel_e          sel;
    logic              clr_req, mask_wr;
    logic [DATA_W-1:0] flag_q, flag_d, mask_q, mask_d;

    always_comb begin
        if (reg_addr == A_FLAG)      sel = SEL_FLAG;
        else if (reg_addr == A_MASK) sel = SEL_MASK;
        else                         sel = SEL_NONE;
    end

    assign clr_req = reg_rd && (sel == SEL_FLAG);
    assign mask_wr = reg_wr && (sel == SEL_MASK);

    lei_flag_bank #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT), .EVT_LSB(EVT_LSB)) i_flags (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .clr_req(clr_req),
        .flag_q(flag_q), .flag_d(flag_d)
    );

    lei_mask_reg #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT), .EVT_LSB(EVT_LSB)) i_mask (
        .clk(clk), .rst_n(rst_n), .wr_req(mask_wr), .wdata(reg_wdata),
        .mask_q(mask_q), .mask_d(mask_d)
    );

    lei_irq_fsm #(.DATA_W(DATA_W)) i_irq (
        .clk(clk), .rst_n(rst_n), .flag_d(flag_d), .mask_d(mask_d),
        .flag_q(flag_q), .mask_q(mask_q), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (sel)
                SEL_FLAG: reg_rdata = flag_q;
                SEL_MASK: reg_rdata = mask_q;
                SEL_NONE: reg_rdata = '0;
                default:  reg_rdata = '0;
            endcase
        end
    end

    assert_idle_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> reg_rdata == '0);

    assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~KEEP) == '0);

    assert_flag_wr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_FLAG && !reg_rd && evt_pulse == '0) |=> $stable(flag_q));

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (irq == 1'b0));
endmodule

// File: tb/test_link_evt_irq_ctrl.sv
module test_link_evt_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  evt_pulse = '0;
    logic [4:0]  reg_addr = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    int m_flag = 0;
    int m_mask = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_evt_irq_ctrl i_link_evt_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // reference model update
    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag <= 0;
            m_mask <= 0;
        end else begin
            int nf = m_flag;
            if (reg_rd && reg_addr == 5'd29) nf = 0;
            for (int i = 0; i < 6; i++) if (evt_pulse[i]) nf = nf | (1 << (i + 1));
            m_flag <= nf;
            if (reg_wr && reg_addr == 5'd30) m_mask <= int'(reg_wdata) & 32'h7E;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int er = 0;
            check("R6 irq", int'(irq), ((m_flag & m_mask) != 0) ? 1 : 0);
            if (reg_rd && reg_addr == 5'd29) begin
                er = m_flag; check("R3 flag read", int'(reg_rdata), er);
            end else if (reg_rd && reg_addr == 5'd30) begin
                er = m_mask; check("R5 mask read", int'(reg_rdata), er);
            end else
                check("R8 rdata zero", int'(reg_rdata), 0);
        end
    end

    task automatic idle();
        evt_pulse = '0; reg_rd = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    endtask

    // apply inputs for one cycle; return rdata and irq seen before the edge
    task automatic step(input logic [5:0] e, input bit rd, input bit wr,
                        input logic [4:0] a, input logic [15:0] wd,
                        output int rdv, output int irqv);
        evt_pulse = e; reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        @(negedge clk);
        rdv = int'(reg_rdata); irqv = int'(irq);
        @(posedge clk); #1;
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int rv, iv;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;

        // R1 reset state
        step('0, 1, 0, 5'd29, '0, rv, iv); check("R1 flags after reset", rv, 0);
        check("R1 irq after reset", iv, 0);
        step('0, 1, 0, 5'd30, '0, rv, iv); check("R1 mask after reset", rv, 0);

        // R2 each event sets its own bit with mask 0; R3 read clears
        for (int i = 0; i < 6; i++) begin
            step(6'(1 << i), 0, 0, '0, '0, rv, iv);
            step('0, 1, 0, 5'd29, '0, rv, iv);
            check("R2 event bit", rv, 1 << (i + 1));
            check("R6 masked irq low", iv, 0);
            step('0, 1, 0, 5'd29, '0, rv, iv);
            check("R3 cleared after read", rv, 0);
        end

        // R7 unused mask bits ignore writes; R5 enable all
        step('0, 0, 1, 5'd30, 16'hFFFF, rv, iv);
        step('0, 1, 0, 5'd30, '0, rv, iv); check("R7 mask unused bits", rv, 32'h7E);
        step('0, 1, 0, 5'd30, '0, rv, iv); check("R5 mask read no clear", rv, 32'h7E);

        step(6'b000001, 0, 0, '0, '0, rv, iv);
        step('0, 0, 0, '0, '0, rv, iv); check("R6 irq raised", iv, 1);

        // R4 collision: flags hold bit1, link-down arrives with the read
        step(6'b001000, 1, 0, 5'd29, '0, rv, iv); check("R4 read pre-event value", rv, 32'h02);
        step('0, 1, 0, 5'd29, '0, rv, iv); check("R4 colliding bit kept", rv, 32'h10);
        check("R4 irq still high", iv, 1);
        step('0, 0, 0, '0, '0, rv, iv); check("R6 irq dropped after clear", iv, 0);

        // R7 write to flag address has no effect
        step('0, 0, 1, 5'd29, 16'hFFFF, rv, iv);
        step('0, 1, 0, 5'd29, '0, rv, iv); check("R7 flag write ignored", rv, 0);

        // R5 partial mask: only link down (bit 4)
        step('0, 0, 1, 5'd30, 16'h0010, rv, iv);
        step(6'b010000, 0, 0, '0, '0, rv, iv);
        step('0, 0, 0, '0, '0, rv, iv); check("R6 remote fault masked", iv, 0);
        step(6'b001000, 0, 0, '0, '0, rv, iv);
        step('0, 0, 0, '0, '0, rv, iv); check("R6 link down raises", iv, 1);
        step('0, 0, 1, 5'd30, 16'h0000, rv, iv);
        step('0, 0, 0, '0, '0, rv, iv); check("R5 mask zero disables", iv, 0);
        step('0, 1, 0, 5'd29, '0, rv, iv); check("R2 flags kept while masked", rv, 32'h30);

        // R8 other addresses and idle port
        step(6'b111111, 1, 0, 5'd5, '0, rv, iv); check("R8 other address", rv, 0);
        step('0, 1, 0, 5'd28, '0, rv, iv); check("R8 neighbour address", rv, 0);
        step('0, 0, 0, 5'd29, '0, rv, iv); check("R8 no read strobe", rv, 0);
        step('0, 1, 0, 5'd29, '0, rv, iv); check("R2 all six set", rv, 32'h7E);

        // random traffic, compared every cycle by the model
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom;
            logic [4:0] a = (r[2:0] < 3) ? 5'd29 : (r[2:0] < 5) ? 5'd30 : 5'(r[12:8]);
            step(6'($urandom & $urandom), r[3], r[4] & r[5], a, 16'($urandom), rv, iv);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule